// File: doc/BRIEF.md
# Byte/Word Data Access Aligner

This block sits between an address generator and a memory that is 16 bits wide. It serves both byte and word loads and stores. On a read it takes the effective byte address, the access size and the addressed memory word, and it returns the value for the internal data bus. On a write it produces the word index, the per-lane write enables and the lane-steered write data. Words are stored little-endian: the low byte is at the even address and the high byte is at the odd address.

The block also returns the post-modified pointer value. The pointer moves by two for a word access and by one for a byte access, in either direction. A word access to an odd address is a fault. The read still completes with the addressed word. The write is blocked, so memory does not change. In both cases a registered trap pulse is raised on the following cycle, together with a copy of the faulting address, so the state before the fault can be examined.

The datapath is combinational. Only the trap pulse, the captured fault address and the reset synchronizer are registered.

Top module: `data_access_aligner`

## Requirements
- R1: For a word access the memory word index `mem_addr` equals `acc_addr` shifted right by one, so address bit 0 is ignored. An aligned word read returns `mem_rdata` unchanged on `rd_data`.
- R2: For a byte read, `acc_addr[0]`=0 places `mem_rdata[7:0]` on `rd_data[7:0]` and `acc_addr[0]`=1 places `mem_rdata[15:8]` there. `rd_data[15:8]` is always zero for a byte read.
- R3: An aligned word write (`acc_write`=1, `acc_byte`=0, `acc_addr[0]`=0) drives `mem_we`=2'b11 and `mem_wdata`=`wr_data`.
- R4: A byte write drives `mem_we`=2'b01 for an even address and 2'b10 for an odd one. Bit 0 of `mem_we` enables the low lane. `mem_wdata` carries `wr_data[7:0]` copied into both bytes.
- R5: A word write to an odd address drives `mem_we`=2'b00.
- R6: A word read from an odd address still returns the full word `mem_rdata` on `rd_data`.
- R7: One clock after an accepted word access (read or write) with `acc_addr[0]`=1, `trap_pulse` is high for that single cycle and `trap_addr` holds the faulting address. `trap_addr` keeps its value until the next fault. No pulse follows any other cycle.
- R8: `ptr_next` is `acc_addr` plus the step when `ptr_mode`=2'b01, minus the step when `ptr_mode`=2'b10, and unchanged for 2'b00 or 2'b11. The step is 2 for word accesses and 1 for byte accesses. The result wraps modulo 2^AW.
- R9: While `acc_valid`=0, `mem_we` is 2'b00 and no trap pulse follows, even if the other inputs describe a fault.
- R10: While `rst_n` is low, `trap_pulse` and `trap_addr` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_byte | input | 1 | 1 = byte size, 0 = word size |
| acc_addr | input | AW | Effective byte address |
| ptr_mode | input | 2 | Post-modify: 01 increment, 10 decrement, else hold |
| wr_data | input | 16 | Store data from the core |
| mem_rdata | input | 16 | Word read from memory |
| mem_addr | output | AW-1 | Memory word index |
| mem_we | output | 2 | Byte-lane write enables, bit 0 = low lane |
| mem_wdata | output | 16 | Lane-steered store data |
| rd_data | output | 16 | Load value for the internal bus |
| ptr_next | output | AW | Post-modified pointer |
| trap_pulse | output | 1 | Address error trap, one cycle |
| trap_addr | output | AW | Address of the most recent fault |

## Verification
Lane steering, write enables and the pointer step are combinational. A wrong lane select, a missing zero fill or a wrong step therefore shows at the ports in the same cycle as the access. A stuck or stale trap register shows one edge later: the pulse is missing or stretched, or `trap_addr` fails to follow a second fault. Back-to-back faults and a fault followed by a clean access tell the two cases apart. A write enable that escapes on a misaligned or idle cycle shows directly on `mem_we`.

// File: rtl/aligner_pkg.sv
package aligner_pkg;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    PM_HOLD  = 2'b00,
    PM_INC   = 2'b01,
    PM_DEC   = 2'b10,
    PM_HOLD2 = 2'b11
  } ptr_mode_e;
endpackage

// File: rtl/aligner_rd_path.sv
module aligner_rd_path
  import aligner_pkg::*;
(
  input  logic              is_byte,
  input  logic              lane_sel,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] rd_data
);
  logic [7:0] picked;

  always_comb begin
    picked = lane_sel ? mem_rdata[15:8] : mem_rdata[7:0];
    if (is_byte) rd_data = {8'h00, picked};
    else         rd_data = mem_rdata;
  end
endmodule

// File: rtl/aligner_wr_path.sv
module aligner_wr_path
  import aligner_pkg::*;
(
  input  logic              valid,
  input  logic              is_write,
  input  logic              is_byte,
  input  logic              lane_sel,
  input  logic              misaligned,
  input  logic [DATA_W-1:0] wr_data,
  output logic [LANES-1:0]  mem_we,
  output logic [DATA_W-1:0] mem_wdata
);
  logic allow;

  always_comb begin
    allow = valid && is_write && !misaligned;
    mem_we = '0;
    if (allow) begin
      if (is_byte) mem_we[lane_sel] = 1'b1;
      else         mem_we = '1;
    end
    if (is_byte) mem_wdata = {LANES{wr_data[7:0]}};
    else         mem_wdata = wr_data;
  end
endmodule

// File: rtl/aligner_step.sv
module aligner_step
  import aligner_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic          is_byte,
  input  logic [1:0]    mode,
  output logic [AW-1:0] next
);
  logic [AW-1:0] step;
  ptr_mode_e     m;

  always_comb begin
    m    = ptr_mode_e'(mode);
    step = is_byte ? AW'(1) : AW'(2);
    unique case (m)
      PM_INC:  next = addr + step;
      PM_DEC:  next = addr - step;
      default: next = addr;
    endcase
  end
endmodule

// File: rtl/aligner_trap_reg.sv
module aligner_trap_reg #(
  parameter int unsigned AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fault,
  input  logic [AW-1:0] fault_addr,
  output logic          trap_pulse,
  output logic [AW-1:0] trap_addr
);
  logic          pulse_d;
  logic          addr_en;
  logic [AW-1:0] addr_d;

  always_comb begin
    pulse_d = fault;
    addr_en = fault;
    addr_d  = fault_addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_pulse <= 1'b0;
      trap_addr  <= '0;
    end else begin
      trap_pulse <= pulse_d;
      if (addr_en) trap_addr <= addr_d;
    end
  end
endmodule

// File: rtl/data_access_aligner.sv
module data_access_aligner
  import aligner_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_byte,
  input  logic [AW-1:0]     acc_addr,
  input  logic [1:0]        ptr_mode,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [AW-2:0]     mem_addr,
  output logic [LANES-1:0]  mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [AW-1:0]     ptr_next,
  output logic              trap_pulse,
  output logic [AW-1:0]     trap_addr
);
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  logic       misaligned;
  logic       fault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  always_comb begin
    rst_sync_n = rst_sync_q[1] & rst_n;
    misaligned = !acc_byte && acc_addr[0];
    fault      = acc_valid && misaligned;
    mem_addr   = acc_addr[AW-1:1];
  end

  aligner_rd_path u_rd (
    .is_byte   (acc_byte),
    .lane_sel  (acc_addr[0]),
    .mem_rdata (mem_rdata),
    .rd_data   (rd_data)
  );

  aligner_wr_path u_wr (
    .valid      (acc_valid),
    .is_write   (acc_write),
    .is_byte    (acc_byte),
    .lane_sel   (acc_addr[0]),
    .misaligned (misaligned),
    .wr_data    (wr_data),
    .mem_we     (mem_we),
    .mem_wdata  (mem_wdata)
  );

  aligner_step #(.AW(AW)) u_step (
    .addr    (acc_addr),
    .is_byte (acc_byte),
    .mode    (ptr_mode),
    .next    (ptr_next)
  );

  aligner_trap_reg #(.AW(AW)) u_trap (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .fault      (fault),
    .fault_addr (acc_addr),
    .trap_pulse (trap_pulse),
    .trap_addr  (trap_addr)
  );
endmodule

// File: rtl/aligner_checker.sv
module aligner_checker #(
  parameter int unsigned AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          acc_byte,
  input logic [AW-1:0] acc_addr,
  input logic [15:0]   mem_rdata,
  input logic [15:0]   rd_data,
  input logic [1:0]    mem_we,
  input logic          trap_pulse,
  input logic [AW-1:0] trap_addr
);
  logic odd_word;
  assign odd_word = acc_valid && !acc_byte && acc_addr[0];

  assert_misaligned_write_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_word && acc_write) |-> (mem_we == 2'b00));

  assert_misaligned_read_completes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (odd_word && !acc_write) |-> (rd_data == mem_rdata));

  assert_trap_follows_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
    odd_word |=> (trap_pulse && trap_addr == $past(acc_addr)));

  assert_no_spurious_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !odd_word |=> !trap_pulse);

  assert_byte_read_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && acc_byte) |-> (rd_data[15:8] == 8'h00));

  assert_byte_lane_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_byte |-> ($countones(mem_we) <= 1));

  assert_idle_no_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (mem_we == 2'b00));
endmodule

bind data_access_aligner aligner_checker #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .acc_valid  (acc_valid),
  .acc_write  (acc_write),
  .acc_byte   (acc_byte),
  .acc_addr   (acc_addr),
  .mem_rdata  (mem_rdata),
  .rd_data    (rd_data),
  .mem_we     (mem_we),
  .trap_pulse (trap_pulse),
  .trap_addr  (trap_addr)
);

// File: tb/data_access_aligner_bench.sv
`timescale 1ns/1ps
module data_access_aligner_bench;
  localparam int AW = 16;
  localparam int NV = 11;
  localparam int VW = 102;

  // {write, byte, mode, addr, mem_rdata, wr_data, exp_rd, exp_we, exp_wdata, exp_ptr}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0,1'b0,2'd1,16'h1234,16'hBEEF,16'h0000,16'hBEEF,2'b00,16'h0000,16'h1236},
    {1'b0,1'b1,2'd2,16'h2000,16'hA55A,16'h0000,16'h005A,2'b00,16'h0000,16'h1FFF},
    {1'b0,1'b1,2'd1,16'h2001,16'hA55A,16'h0000,16'h00A5,2'b00,16'h0000,16'h2002},
    {1'b1,1'b0,2'd1,16'h0100,16'h0000,16'hCAFE,16'h0000,2'b11,16'hCAFE,16'h0102},
    {1'b1,1'b1,2'd0,16'h0040,16'h0000,16'h1234,16'h0000,2'b01,16'h3434,16'h0040},
    {1'b1,1'b1,2'd2,16'h0041,16'h0000,16'h00C3,16'h0000,2'b10,16'hC3C3,16'h0040},
    {1'b1,1'b0,2'd1,16'h0303,16'h1111,16'h7777,16'h1111,2'b00,16'h7777,16'h0305},
    {1'b0,1'b0,2'd1,16'h0FFF,16'h4321,16'h0000,16'h4321,2'b00,16'h0000,16'h1001},
    {1'b0,1'b0,2'd2,16'h0000,16'h0000,16'h0000,16'h0000,2'b00,16'h0000,16'hFFFE},
    {1'b0,1'b1,2'd1,16'hFFFF,16'h9900,16'h0000,16'h0099,2'b00,16'h0000,16'h0000},
    {1'b0,1'b0,2'd3,16'h0010,16'h0000,16'h0000,16'h0000,2'b00,16'h0000,16'h0010}
  };

  logic          clk;
  logic          rst_n;
  logic          acc_valid, acc_write, acc_byte;
  logic [AW-1:0] acc_addr;
  logic [1:0]    ptr_mode;
  logic [15:0]   wr_data, mem_rdata;
  logic [AW-2:0] mem_addr;
  logic [1:0]    mem_we;
  logic [15:0]   mem_wdata, rd_data;
  logic [AW-1:0] ptr_next;
  logic          trap_pulse;
  logic [AW-1:0] trap_addr;

  int            n_chk;
  int            n_fail;
  logic [VW-1:0] cur;
  logic [AW-1:0] exp_taddr;
  logic          exp_trap;

  data_access_aligner #(.AW(AW)) u_data_access_aligner (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_byte(acc_byte), .acc_addr(acc_addr), .ptr_mode(ptr_mode),
    .wr_data(wr_data), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .rd_data(rd_data),
    .ptr_next(ptr_next), .trap_pulse(trap_pulse), .trap_addr(trap_addr)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic drive(input logic v, input logic w, input logic b, input logic [AW-1:0] a,
                       input logic [1:0] m, input logic [15:0] wd, input logic [15:0] rd);
    @(negedge clk);
    acc_valid = v; acc_write = w; acc_byte = b; acc_addr = a;
    ptr_mode = m; wr_data = wd; mem_rdata = rd;
  endtask

  task automatic trap_check(input logic e_pulse, input logic [AW-1:0] e_addr, input string tag);
    @(posedge clk); #1;
    chk(trap_pulse == e_pulse, tag, 32'(trap_pulse), 32'(e_pulse));
    chk(trap_addr == e_addr, tag, 32'(trap_addr), 32'(e_addr));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    n_chk = 0; n_fail = 0; exp_taddr = '0;
    rst_n = 1'b0; acc_valid = 1'b0; acc_write = 1'b0; acc_byte = 1'b0;
    acc_addr = '0; ptr_mode = 2'b00; wr_data = '0; mem_rdata = '0;
    #1;
    chk(trap_pulse == 1'b0, "R10 reset pulse", 32'(trap_pulse), 0);
    chk(trap_addr == '0, "R10 reset addr", 32'(trap_addr), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    for (int i = 0; i < NV; i++) begin
      cur = VEC[i];
      drive(1'b1, cur[101], cur[100], cur[97:82], cur[99:98], cur[65:50], cur[81:66]);
      #1;
      chk(rd_data == cur[49:34], "R1 R2 R6 rd_data", 32'(rd_data), 32'(cur[49:34]));
      chk(mem_we == cur[33:32], "R3 R4 R5 mem_we", 32'(mem_we), 32'(cur[33:32]));
      chk(mem_wdata == cur[31:16], "R3 R4 mem_wdata", 32'(mem_wdata), 32'(cur[31:16]));
      chk(ptr_next == cur[15:0], "R8 ptr_next", 32'(ptr_next), 32'(cur[15:0]));
      chk(mem_addr == cur[97:83], "R1 mem_addr", 32'(mem_addr), 32'(cur[97:83]));
      exp_trap = !cur[100] && cur[82];
      if (exp_trap) exp_taddr = cur[97:82];
      trap_check(exp_trap, exp_taddr, "R7 trap after vector");
    end

    // R9: idle cycle that looks like a misaligned word write
    drive(1'b0, 1'b1, 1'b0, 16'h0555, 2'd1, 16'hFFFF, 16'h0000);
    #1;
    chk(mem_we == 2'b00, "R9 idle mem_we", 32'(mem_we), 0);
    trap_check(1'b0, exp_taddr, "R9 idle no trap");

    // R7: back-to-back faults, each pulses and updates the address
    drive(1'b1, 1'b0, 1'b0, 16'h1001, 2'd0, 16'h0000, 16'h0000);
    trap_check(1'b1, 16'h1001, "R7 first fault");
    drive(1'b1, 1'b1, 1'b0, 16'h2003, 2'd0, 16'hAAAA, 16'h0000);
    #1;
    chk(mem_we == 2'b00, "R5 second fault write blocked", 32'(mem_we), 0);
    trap_check(1'b1, 16'h2003, "R7 second fault");
    drive(1'b1, 1'b0, 1'b0, 16'h2004, 2'd0, 16'h0000, 16'h0000);
    trap_check(1'b0, 16'h2003, "R7 pulse drops, addr held");

    // R10: reset mid-run clears the captured address
    drive(1'b0, 1'b0, 1'b0, 16'h0000, 2'd0, 16'h0000, 16'h0000);
    rst_n = 1'b0;
    #1;
    chk(trap_addr == '0, "R10 reset clears addr", 32'(trap_addr), 0);
    chk(trap_pulse == 1'b0, "R10 reset clears pulse", 32'(trap_pulse), 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);

    finish_run();
  end
endmodule